// File: doc/BRIEF.md
# Triggered DAC Data-Transfer Controller

This block is the digital front end of a single DAC channel. Software writes a 12-bit code into a holding register over a small write-only register bus. The block then decides when that code is copied into the output register that drives the converter. Codes run from 0 to 4095, and 4095 is full scale.

A control register selects one of two modes. In direct mode (trigger enable clear), the output register follows the holding register one cycle after each write. In triggered mode, a 3-bit select code chooses one of eight sources: six timer trigger lines, one external line, or a self-clearing software request bit. A rising edge on the chosen source arms a fixed three-cycle countdown, and the copy happens at the end of it.

The state machine has four states:

- `ST_DIRECT`: trigger enable clear; the output follows the holding register.
- `ST_IDLE`: waiting for an edge.
- `ST_WAIT`: countdown in progress.
- `ST_LOAD`: copy cycle.

Its transitions are:

- Any state goes to `ST_DIRECT` whenever the enable is clear.
- `ST_DIRECT` goes to `ST_IDLE` on the first cycle with the enable set.
- `ST_IDLE` goes to `ST_WAIT` when an accepted edge arrives.
- `ST_WAIT` goes to `ST_LOAD` when the countdown reaches zero.
- `ST_LOAD` returns to `ST_IDLE`.

Top module: `dac_xfer_ctrl`

## Requirements
- R1: In triggered mode the select code picks the trigger source. Codes 0 to 5 pick `tmr_trg[code]`, code 6 picks `ext_line`, and code 7 picks the software request bit. Edges on sources that are not selected cause no transfer.
- R2: Triggers take effect only while the enable bit is set. A software request set while the enable is clear stays set and causes no transfer. After the enable is set, triggers are accepted from the second cycle on.
- R3: A trigger is a rising edge of the selected source. A source held high causes no further transfer. In triggered mode, without a trigger, `dac_code` keeps its value even when the holding register changes.
- R4: A transfer copies the holding register value that is present at the clock edge of the load cycle. A write landing on that same edge is not taken. A write landing earlier in the countdown is taken.
- R5: `dac_code` changes on the third rising clock edge after the edge at which the trigger is detected.
- R6: A bus write to address 0 with bit 4 set raises the software request bit (`sw_trig`). A write with bit 4 clear leaves the bit unchanged. With code 7 selected, the rise is detected on the next clock edge.
- R7: The software request bit clears on the edge at which `dac_code` is loaded by a trigger. If a write setting the bit lands on that same edge, the clear wins.
- R8: Data codes are 12 bits, taken from `wr_data[11:0]` at address 1. Codes 0 and 4095 pass through unchanged.
- R9: With the enable clear, a holding write reaches `dac_code` on the next clock edge.
- R10: A trigger edge that arrives while a transfer is counting down or loading is ignored.
- R11: Synchronous active-high reset clears the holding register, `dac_code`, the control register (enable clear, select 0), the pending state and the software request bit.

The control register at address 0 has these fields:

- bit 0: trigger enable.
- bits 3:1: select code.
- bit 4: software request set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects control, 1 selects holding data |
| wr_data | input | 12 | Write data |
| tmr_trg | input | 6 | Timer trigger lines, select codes 0 to 5 |
| ext_line | input | 1 | External trigger line, select code 6 |
| dac_code | output | 12 | Output register driving the converter |
| sw_trig | output | 1 | Current value of the software request bit |

## Verification
Two functions can fall on the load edge: the copy into `dac_code`, and a bus write to the holding register or a write setting the software request bit. The bench provokes this by counting edges from trigger detection and timing the write to land exactly on the third one. It judges the outcome in two ways. `dac_code` must carry the value from before that write. `sw_trig` must read zero afterwards and must stay zero.

// File: rtl/dac_xfer_pkg.sv
package dac_xfer_pkg;

    typedef enum logic [1:0] {
        ST_DIRECT = 2'd0,
        ST_IDLE   = 2'd1,
        ST_WAIT   = 2'd2,
        ST_LOAD   = 2'd3
    } xfer_state_t;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_SEL_LSB = 1;
    localparam int CTRL_SW_BIT  = 4;

endpackage

// File: rtl/dac_xfer_regs.sv
module dac_xfer_regs
    import dac_xfer_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load_i,
    output logic              en_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic              sw_o,
    output logic [DATA_W-1:0] hold_o
);

    logic ctrl_wr;
    logic data_wr;

    assign ctrl_wr = wr_en && (wr_addr == 1'b0);
    assign data_wr = wr_en && (wr_addr == 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_o   <= 1'b0;
            sel_o  <= '0;
            hold_o <= '0;
        end else begin
            if (ctrl_wr) begin
                en_o  <= wr_data[CTRL_EN_BIT];
                sel_o <= wr_data[CTRL_SEL_LSB +: SEL_W];
            end
            if (data_wr) begin
                hold_o <= wr_data;
            end
        end
    end

    // Software request: write-one-to-set, hardware clear on load wins.
    always_ff @(posedge clk) begin
        if (rst) begin
            sw_o <= 1'b0;
        end else if (load_i) begin
            sw_o <= 1'b0;
        end else if (ctrl_wr && wr_data[CTRL_SW_BIT]) begin
            sw_o <= 1'b1;
        end
    end

    a_r7_sw_clear: assert property (@(posedge clk) disable iff (rst)
        load_i |=> !sw_o);

    a_r6_sw_set: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && wr_data[CTRL_SW_BIT] && !load_i) |=> sw_o);

endmodule

// File: rtl/dac_trig_sel.sv
module dac_trig_sel #(
    parameter int SEL_W   = 3,
    parameter int NUM_TMR = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic [NUM_TMR-1:0] tmr_i,
    input  logic               ext_i,
    input  logic               sw_i,
    output logic               rise_o
);

    localparam int NUM_SRC = 2 ** SEL_W;

    logic [NUM_SRC-1:0] src_vec;
    logic               src;
    logic               src_prev;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        if (i < NUM_TMR) begin : g_tmr
            assign src_vec[i] = tmr_i[i];
        end else if (i == NUM_TMR) begin : g_ext
            assign src_vec[i] = ext_i;
        end else begin : g_sw
            assign src_vec[i] = sw_i;
        end
    end

    assign src = src_vec[sel_i];

    always_ff @(posedge clk) begin
        if (rst) begin
            src_prev <= 1'b0;
        end else begin
            src_prev <= src;
        end
    end

    assign rise_o = src && !src_prev;

    a_r3_edge_only: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

endmodule

// File: rtl/dac_xfer_fsm.sv
module dac_xfer_fsm
    import dac_xfer_pkg::*;
#(
    parameter int DATA_W  = 12,
    parameter int LATENCY = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              rise_i,
    input  logic [DATA_W-1:0] hold_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              load_o
);

    localparam int CNT_W = (LATENCY > 2) ? $clog2(LATENCY - 1) : 1;

    xfer_state_t      state_q;
    xfer_state_t      state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!en_i) begin
            state_d = ST_DIRECT;
        end else begin
            unique case (state_q)
                ST_DIRECT: state_d = ST_IDLE;
                ST_IDLE: begin
                    if (rise_i) begin
                        state_d = ST_WAIT;
                        cnt_d   = CNT_W'(LATENCY - 2);
                    end
                end
                ST_WAIT: begin
                    if (cnt_q == '0) begin
                        state_d = ST_LOAD;
                    end else begin
                        cnt_d = cnt_q - CNT_W'(1);
                    end
                end
                ST_LOAD: state_d = ST_IDLE;
                default: state_d = ST_DIRECT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_DIRECT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign load_o = en_i && (state_q == ST_LOAD);

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_o <= '0;
        end else if (!en_i || load_o) begin
            dout_o <= hold_i;
        end
    end

    a_r5_arm: assert property (@(posedge clk) disable iff (rst || !en_i)
        (state_q == ST_IDLE && rise_i) |=> (state_q == ST_WAIT));

    a_r4_copy: assert property (@(posedge clk) disable iff (rst)
        (en_i && state_q == ST_LOAD) |=> (dout_o == $past(hold_i)));

    a_r3_hold_value: assert property (@(posedge clk) disable iff (rst)
        (en_i && state_q != ST_LOAD) |=> $stable(dout_o));

    a_r9_direct: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (dout_o == $past(hold_i)));

    a_r10_no_rearm: assert property (@(posedge clk) disable iff (rst || !en_i)
        (state_q == ST_WAIT || state_q == ST_LOAD) |=> (state_q != ST_IDLE || $past(state_q) == ST_LOAD));

endmodule

// File: rtl/dac_xfer_ctrl.sv
module dac_xfer_ctrl #(
    parameter int DATA_W  = 12,
    parameter int SEL_W   = 3,
    parameter int NUM_TMR = 6,
    parameter int LATENCY = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [NUM_TMR-1:0] tmr_trg,
    input  logic               ext_line,
    output logic [DATA_W-1:0]  dac_code,
    output logic               sw_trig
);

    logic              en;
    logic [SEL_W-1:0]  sel;
    logic [DATA_W-1:0] hold;
    logic              rise;
    logic              load;

    dac_xfer_regs #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .load_i  (load),
        .en_o    (en),
        .sel_o   (sel),
        .sw_o    (sw_trig),
        .hold_o  (hold)
    );

    dac_trig_sel #(.SEL_W(SEL_W), .NUM_TMR(NUM_TMR)) u_sel (
        .clk    (clk),
        .rst    (rst),
        .sel_i  (sel),
        .tmr_i  (tmr_trg),
        .ext_i  (ext_line),
        .sw_i   (sw_trig),
        .rise_o (rise)
    );

    dac_xfer_fsm #(.DATA_W(DATA_W), .LATENCY(LATENCY)) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .en_i   (en),
        .rise_i (rise),
        .hold_i (hold),
        .dout_o (dac_code),
        .load_o (load)
    );

    a_r11_reset: assert property (@(posedge clk)
        rst |=> (dac_code == '0 && !sw_trig));

endmodule

// File: tb/dac_xfer_ctrl_bench.sv
module dac_xfer_ctrl_bench;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic        wr_addr;
    logic [11:0] wr_data;
    logic [5:0]  tmr_trg;
    logic        ext_line;
    logic [11:0] dac_code;
    logic        sw_trig;

    int checks = 0;
    int errors = 0;
    int exp_out;

    always #(CLK_P / 2) clk = ~clk;

    dac_xfer_ctrl u_dac_xfer_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .tmr_trg  (tmr_trg),
        .ext_line (ext_line),
        .dac_code (dac_code),
        .sw_trig  (sw_trig)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic addr, input int data);
        wr_en   = 1'b1;
        wr_addr = addr;
        wr_data = 12'(data);
        step();
        wr_en   = 1'b0;
    endtask

    // Control word: bit0 enable, bits 3:1 select, bit4 software set.
    function automatic int ctrl(input int en, input int sel, input int sw);
        return en | (sel << 1) | (sw << 4);
    endfunction

    task automatic set_line(input int idx, input logic val);
        if (idx < 6) tmr_trg[idx] = val;
        else ext_line = val;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0;
        tmr_trg = '0; ext_line = 1'b0;
        @(negedge clk);
        do_reset();
        chk("R11 dac_code after reset", dac_code, 0);
        chk("R11 sw_trig after reset", sw_trig, 0);

        // Direct mode
        bus_write(1'b1, 12'hABC);
        chk("R9 not before next edge", dac_code, 0);
        step();
        chk("R9 direct one cycle", dac_code, 12'hABC);
        bus_write(1'b1, 4095);
        step();
        chk("R8 full scale", dac_code, 4095);
        bus_write(1'b1, 0);
        step();
        chk("R8 zero code", dac_code, 0);

        // Software request while disabled
        bus_write(1'b0, ctrl(0, 7, 1));
        chk("R6 sw set", sw_trig, 1);
        repeat (6) step();
        chk("R2 sw stays while disabled", sw_trig, 1);
        bus_write(1'b0, ctrl(0, 7, 0));
        step();
        chk("R6 write zero keeps sw", sw_trig, 1);
        do_reset();
        chk("R11 reset clears sw", sw_trig, 0);

        // Sweep over all select codes
        exp_out = 0;
        bus_write(1'b0, ctrl(1, 0, 0));
        step(); step();
        for (int s = 0; s < 8; s++) begin
            int v;
            v = (s * 12'h2A7 + 12'h135) & 12'hFFF;
            bus_write(1'b0, ctrl(1, s, 0));
            bus_write(1'b1, v);
            step(); step();
            chk("R3 no copy without trigger", dac_code, exp_out);
            for (int j = 0; j < 7; j++) begin
                if (j != s) begin
                    set_line(j, 1'b1);
                    step();
                    set_line(j, 1'b0);
                    repeat (4) step();
                end
            end
            chk("R1 unselected sources ignored", dac_code, exp_out);
            if (s < 7) begin
                set_line(s, 1'b1);
                repeat (3) step();
                chk("R5 not before third edge", dac_code, exp_out);
                step();
                chk("R1 R5 selected source loads", dac_code, v);
                set_line(s, 1'b0);
                step();
            end else begin
                bus_write(1'b0, ctrl(1, 7, 1));
                chk("R6 sw raised", sw_trig, 1);
                repeat (3) step();
                chk("R5 sw not early", dac_code, exp_out);
                step();
                chk("R1 sw transfer", dac_code, v);
                chk("R7 sw cleared on load", sw_trig, 0);
            end
            exp_out = v;
        end

        // Level held high does not re-trigger
        bus_write(1'b0, ctrl(1, 0, 0));
        step(); step();
        bus_write(1'b1, 12'h111);
        tmr_trg[0] = 1'b1;
        repeat (4) step();
        chk("R3 edge loads", dac_code, 12'h111);
        bus_write(1'b1, 12'h222);
        repeat (6) step();
        chk("R3 level held no reload", dac_code, 12'h111);
        tmr_trg[0] = 1'b0;
        step();

        // Write inside the countdown is taken
        tmr_trg[0] = 1'b1;
        step();
        bus_write(1'b1, 12'h333);
        step();
        chk("R5 still old at second edge", dac_code, 12'h111);
        step();
        chk("R4 write in window taken", dac_code, 12'h333);
        tmr_trg[0] = 1'b0;
        step();

        // Write on the load edge is not taken
        bus_write(1'b1, 12'h555);
        tmr_trg[0] = 1'b1;
        repeat (3) step();
        bus_write(1'b1, 12'h666);
        chk("R4 load-edge write not taken", dac_code, 12'h555);
        step(); step();
        chk("R4 no second load", dac_code, 12'h555);
        tmr_trg[0] = 1'b0;
        step();

        // Edge during pending transfer ignored
        bus_write(1'b1, 12'h777);
        tmr_trg[0] = 1'b1;
        step();
        tmr_trg[0] = 1'b0;
        step();
        tmr_trg[0] = 1'b1;
        step(); step();
        chk("R5 load from first edge", dac_code, 12'h777);
        bus_write(1'b1, 12'h888);
        repeat (5) step();
        chk("R10 pending edge ignored", dac_code, 12'h777);
        tmr_trg[0] = 1'b0;
        step();

        // Software set colliding with load edge
        bus_write(1'b0, ctrl(1, 7, 0));
        step(); step();
        bus_write(1'b1, 12'h9AB);
        bus_write(1'b0, ctrl(1, 7, 1));
        repeat (3) step();
        bus_write(1'b0, ctrl(1, 7, 1));
        chk("R7 clear wins over set", sw_trig, 0);
        chk("R7 load happened", dac_code, 12'h9AB);
        repeat (4) step();
        chk("R7 sw stays clear", sw_trig, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule